// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial characters on a single line and turns them into parallel bytes. A packed 8-bit configuration byte sets the whole frame format. Bits 1:0 pick how many receive-clock ticks make up one bit period. Bits 3:2 pick the character length. Bits 5:4 control parity. Bits 7:6 hold the stop-bit setting. The receive clock is a one-cycle enable, `rxTick`, in the system clock domain. It pulses at the chosen multiple of the bit rate, and the receiver moves forward only on those pulses.

Each finished character gives a one-cycle `rxValid` strobe. The right-aligned data and the parity and framing flags are held until the next character. A separate break output rises with any character whose every sampled bit is low, including parity and stop. It stays high until the line is seen high again.

Top module: `serial_rx_brk`

## Requirements
- R1: Configuration bits 1:0 set the ticks per bit: 01 gives 1, 10 gives 16 and 11 gives 64. With 00 the receiver stays idle and ignores the line.
- R2: With 16 or 64 ticks per bit, the first low sample starts a start-bit check, and the line is sampled again N/2 ticks later. If that sample is high, the attempt is dropped with no output. If it is low, every later bit is sampled N ticks after the previous sample.
- R3: Configuration bits 3:2 = 00/01/10/11 select 5/6/7/8 data bits. Bits arrive least significant first. `rxData` holds them right-aligned, and the unused upper bits read zero.
- R4: Configuration bit 4 = 1 adds a parity bit after the data. Bit 5 = 1 selects even parity and 0 selects odd. `parityErr` is 1 when the received parity does not match, and it is always 0 when parity is disabled.
- R5: Only the first stop bit is sampled, whatever bits 7:6 hold. `framingErr` is 1 exactly when that sample is low.
- R6: `rxValid` is high for one clock, in the cycle after the tick that samples the stop bit. `rxData`, `parityErr` and `framingErr` change only together with `rxValid` and hold their values in between.
- R7: `breakDet` rises together with `rxValid` when the data, parity (if enabled) and stop samples are all low. It falls after the first later tick that samples the line high.
- R8: After a character with a low stop sample, no new start is accepted until a tick has sampled the line high.
- R9: The configuration is captured when a start is detected. Changes to `modeByte` during a character do not affect that character.
- R10: Only clocks with `rxTick` high advance reception. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxTick | input | 1 | Receive-clock enable, pulsed at N times the bit rate |
| modeByte | input | 8 | Packed frame configuration |
| rxIn | input | 1 | Serial input line, idle high |
| rxData | output | 8 | Last received character, right-aligned |
| rxValid | output | 1 | One-cycle strobe for a new character |
| parityErr | output | 1 | Parity mismatch on the last character |
| framingErr | output | 1 | Stop sample was low on the last character |
| breakDet | output | 1 | All-zero character seen; held until the line goes high |

## Verification
The bench checks that the start check happens at mid-bit by sending a low pulse shorter than half a bit. A receiver that skipped the check would report a false character. A receiver that only samples on a framing error, instead of waiting for the line to go high, would read a held-low break as a stream of characters. The bench also changes the configuration in the middle of a character, so a receiver that failed to capture it at the start would sample at the wrong rate. Gapped ticks show any logic that counts system clocks instead of ticks. Short characters and the odd and even parity cases show wrong alignment or an inverted parity sense.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W = 8;
  localparam int MODE_W = 8;
  localparam int MAX_FACTOR = 64;
  localparam int IDX_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(MAX_FACTOR);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH
  } rxStateT;

  typedef struct packed {
    logic             clrShift;
    logic             takeData;
    logic [IDX_W-1:0] bitIdx;
    logic             takePar;
    logic             finish;
    logic             lineHigh;
  } rxStrobeT;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxTick,
  input  logic              rxIn,
  input  logic [MODE_W-1:0] modeByte,
  output rxStrobeT          strb,
  output logic [MODE_W-1:0] curMode
);
  rxStateT          state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] bitNo;
  logic [CNT_W:0]   nFac;
  logic [CNT_W:0]   halfCnt;
  logic [CNT_W:0]   lastCnt;
  logic [IDX_W-1:0] lastBit;
  logic             sampleNow;
  logic             startSeen;

  function automatic logic [CNT_W:0] factorOf(input logic [1:0] sel);
    case (sel)
      2'b01:   factorOf = (CNT_W+1)'(1);
      2'b10:   factorOf = (CNT_W+1)'(16);
      2'b11:   factorOf = (CNT_W+1)'(MAX_FACTOR);
      default: factorOf = '0;
    endcase
  endfunction

  assign nFac      = factorOf(curMode[1:0]);
  assign halfCnt   = (nFac >> 1) - (CNT_W+1)'(1);
  assign lastCnt   = nFac - (CNT_W+1)'(1);
  assign lastBit   = IDX_W'(DATA_W - 4) + IDX_W'(curMode[3:2]);
  assign sampleNow = (cnt == lastCnt[CNT_W-1:0]);
  assign startSeen = (state == S_IDLE) && (modeByte[1:0] != 2'b00) && !rxIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitNo   <= '0;
      curMode <= '0;
    end else if (rxTick) begin
      case (state)
        S_IDLE: if (startSeen) begin
          curMode <= modeByte;
          cnt     <= '0;
          bitNo   <= '0;
          state   <= (modeByte[1:0] == 2'b01) ? S_DATA : S_START;
        end
        S_START: begin
          if (cnt == halfCnt[CNT_W-1:0]) begin
            cnt   <= '0;
            state <= rxIn ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (sampleNow) begin
            cnt <= '0;
            if (bitNo == lastBit) state <= curMode[4] ? S_PAR : S_STOP;
            else bitNo <= bitNo + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (sampleNow) begin
            cnt   <= '0;
            state <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (sampleNow) begin
            cnt   <= '0;
            state <= rxIn ? S_IDLE : S_WAITH;
          end else cnt <= cnt + 1'b1;
        end
        S_WAITH: if (rxIn) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.bitIdx = bitNo;
    if (rxTick) begin
      strb.clrShift = startSeen;
      strb.takeData = (state == S_DATA) && sampleNow;
      strb.takePar  = (state == S_PAR) && sampleNow;
      strb.finish   = (state == S_STOP) && sampleNow;
      strb.lineHigh = (state == S_WAITH) && rxIn;
    end
  end
endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxIn,
  input  rxStrobeT          strb,
  input  logic [MODE_W-1:0] modeCur,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakDet
);
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic              parEn;
  logic              parEven;
  logic              xorAll;
  logic              unusedModeBits;

  assign parEn          = modeCur[4];
  assign parEven        = modeCur[5];
  assign xorAll         = (^shiftReg) ^ parBit;
  assign unusedModeBits = ^{modeCur[7:6], modeCur[3:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      parBit     <= 1'b0;
      rxData     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      framingErr <= 1'b0;
      breakDet   <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.clrShift) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end
      if (strb.takeData) shiftReg[strb.bitIdx] <= rxIn;
      if (strb.takePar)  parBit <= rxIn;
      if (strb.finish) begin
        rxData     <= shiftReg;
        rxValid    <= 1'b1;
        parityErr  <= parEn & (xorAll ^ ~parEven);
        framingErr <= ~rxIn;
        breakDet   <= (shiftReg == '0) && !parBit && !rxIn;
      end else if (strb.lineHigh) begin
        breakDet <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_rx_brk.sv
module serial_rx_brk
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxTick,
  input  logic [MODE_W-1:0] modeByte,
  input  logic              rxIn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakDet
);
  rxStrobeT          strb;
  logic [MODE_W-1:0] curMode;

  serial_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxTick(rxTick), .rxIn(rxIn),
    .modeByte(modeByte), .strb(strb), .curMode(curMode)
  );

  serial_rx_dpath u_dpath (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .strb(strb), .modeCur(curMode),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .framingErr(framingErr), .breakDet(breakDet)
  );
endmodule

// File: rtl/serial_rx_brk_chk.sv
module serial_rx_brk_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxTick,
  input logic [7:0] curMode,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       parityErr,
  input logic       framingErr,
  input logic       breakDet
);
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> $stable(rxData));

  assert_break_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakDet) |-> (rxValid && framingErr && rxData == 8'h00));

  assert_short_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && curMode[3:2] == 2'b00) |-> (rxData[7:5] == 3'b000));

  assert_no_parity_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !curMode[4]) |-> !parityErr);

  assert_tick_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxTick) |-> !rxValid);
endmodule

bind serial_rx_brk serial_rx_brk_chk u_chk (
  .clk(clk), .rstN(rstN), .rxTick(rxTick), .curMode(curMode),
  .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
  .framingErr(framingErr), .breakDet(breakDet)
);

// File: tb/sim_serial_rx_brk.sv
`timescale 1ns/1ps
module sim_serial_rx_brk;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxTick = 1'b1;
  logic [7:0] modeByte = 8'h00;
  logic       rxIn = 1'b1;
  logic [7:0] rxData;
  logic       rxValid, parityErr, framingErr, breakDet;

  int    nTests = 0;
  int    nFail = 0;
  string curReq = "R10";
  bit    checking = 1'b0;
  bit    gapTicks = 1'b0;

  // reference model state
  int tickCnt = 0;
  int qTick[$];
  int qData[$];
  int qPe[$];
  int qFe[$];
  int qBrk[$];
  int expValid = 0, expData = 0, expPe = 0, expFe = 0, expBrk = 0;
  bit waitHigh = 1'b0;

  serial_rx_brk u0 (
    .clk(clk), .rstN(rstN), .rxTick(rxTick), .modeByte(modeByte), .rxIn(rxIn),
    .rxData(rxData), .rxValid(rxValid), .parityErr(parityErr),
    .framingErr(framingErr), .breakDet(breakDet)
  );

  always #10 clk = ~clk;

  always @(negedge clk) rxTick <= gapTicks ? ~rxTick : 1'b1;

  // behavioural model: expected results are keyed on the tick count
  always @(posedge clk) begin
    if (!rstN) begin
      tickCnt = 0; expValid = 0; expData = 0; expPe = 0; expFe = 0; expBrk = 0;
      waitHigh = 1'b0;
    end else begin
      expValid = 0;
      if (rxTick) begin
        tickCnt++;
        if (qTick.size() > 0 && qTick[0] == tickCnt) begin
          expValid = 1;
          expData = qData.pop_front();
          expPe = qPe.pop_front();
          expFe = qFe.pop_front();
          if (qBrk.pop_front() != 0) expBrk = 1;
          void'(qTick.pop_front());
          if (expFe != 0) waitHigh = 1'b1;
        end else if (waitHigh && rxIn) begin
          waitHigh = 1'b0;
          expBrk = 0;
        end
      end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("rxValid", int'(rxValid), expValid);
      chk("rxData", int'(rxData), expData);
      chk("parityErr", int'(parityErr), expPe);
      chk("framingErr", int'(framingErr), expFe);
      chk("breakDet", int'(breakDet), expBrk);
    end
  end

  function automatic int factorOf(input logic [7:0] m);
    case (m[1:0])
      2'b01: return 1;
      2'b10: return 16;
      2'b11: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic holdLine(input logic v, input int ticks);
    rxIn = v;
    for (int k = 0; k < ticks; ) begin
      @(posedge clk);
      if (rxTick) k++;
    end
    @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] mode, input logic [7:0] data,
                           input bit badPar, input bit stopLow, input bit swapMode);
    int n, len, pen;
    logic [7:0] dm;
    logic pb;
    n = factorOf(mode);
    len = 5 + int'(mode[3:2]);
    pen = int'(mode[4]);
    dm = data & ((8'h01 << len) - 8'h01);
    pb = mode[5] ? (^dm) : ~(^dm);
    if (badPar) pb = ~pb;
    modeByte = mode;
    qTick.push_back(tickCnt + 1 + n / 2 + n * (len + pen + 1));
    qData.push_back(int'(dm));
    qPe.push_back((badPar && pen != 0) ? 1 : 0);
    qFe.push_back(stopLow ? 1 : 0);
    qBrk.push_back((stopLow && dm == 8'h00 && !(pen != 0 && pb)) ? 1 : 0);
    holdLine(1'b0, n);
    if (swapMode) modeByte = ~mode;
    for (int i = 0; i < len; i++) holdLine(dm[i], n);
    if (pen != 0) holdLine(pb, n);
    holdLine(stopLow ? 1'b0 : 1'b1, 2 * n);
  endtask

  initial begin
    #(200000 * 20);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R10"; // reset state: all outputs zero
    chk("reset rxValid", int'(rxValid), 0);
    chk("reset rxData", int'(rxData), 0);
    chk("reset breakDet", int'(breakDet), 0);
    rstN = 1'b1;
    @(negedge clk);
    checking = 1'b1;
    holdLine(1'b1, 5);

    curReq = "R1 R2 R3 R6";   // x16, 8 bits, no parity
    sendFrame(8'h4E, 8'hA5, 0, 0, 0);
    holdLine(1'b1, 20);
    curReq = "R3 R4";         // x1, 5 bits, even parity
    sendFrame(8'h71, 8'h13, 0, 0, 0);
    holdLine(1'b1, 5);
    curReq = "R1 R4 R5";      // x64, 7 bits, odd parity, two stop bits
    sendFrame(8'hDB, 8'h55, 0, 0, 0);
    holdLine(1'b1, 70);
    curReq = "R3";            // 6 bits
    sendFrame(8'h46, 8'h2A, 0, 0, 0);
    holdLine(1'b1, 20);
    curReq = "R4";            // bad even parity, then bad odd parity
    sendFrame(8'h71, 8'h0C, 1, 0, 0);
    holdLine(1'b1, 5);
    sendFrame(8'h5E, 8'h6B, 1, 0, 0);
    holdLine(1'b1, 20);
    curReq = "R5 R8";         // framing error, line held low afterwards
    sendFrame(8'h4E, 8'h3C, 0, 1, 0);
    holdLine(1'b0, 40);
    holdLine(1'b1, 20);
    curReq = "R7";            // break, held low, then released
    sendFrame(8'h4E, 8'h00, 0, 1, 0);
    holdLine(1'b0, 50);
    holdLine(1'b1, 20);
    curReq = "R7 R4";         // break with even parity enabled
    sendFrame(8'h7E, 8'h00, 0, 1, 0);
    holdLine(1'b1, 20);
    curReq = "R1";            // mode 00 ignores the line
    modeByte = 8'h4C;
    holdLine(1'b0, 40);
    holdLine(1'b1, 20);
    curReq = "R2";            // glitch shorter than half a bit
    modeByte = 8'h4E;
    holdLine(1'b0, 3);
    holdLine(1'b1, 30);
    curReq = "R9";            // mode changed mid-character
    sendFrame(8'h4E, 8'h96, 0, 0, 1);
    holdLine(1'b1, 20);
    curReq = "R10";           // gapped ticks
    gapTicks = 1'b1;
    holdLine(1'b1, 4);
    sendFrame(8'h4E, 8'h81, 0, 0, 0);
    holdLine(1'b1, 20);
    gapTicks = 1'b0;
    holdLine(1'b1, 10);

    checking = 1'b0;
    curReq = "R6";
    chk("pending characters", qTick.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule